// File: doc/BRIEF.md
# Four-bit cascadable arithmetic logic unit

This block is a purely combinational 4-bit arithmetic logic unit. It takes two operands, a 4-bit function select and a mode input. In logic mode it produces one of sixteen bitwise functions of the operands. In arithmetic mode it produces one of sixteen sums, and the carry input takes part in the result.

Each bit position forms a generate term and a propagate term from its operand bits and the select lines. The carries into all four positions are computed at the same time by a full lookahead network inside the group, so no carry ripples from bit to bit. The group exports active-low generate and propagate signals, which an external lookahead unit can combine across several groups. The group also has an active-low carry input and an active-low carry output, so short words can be chained by plain ripple.

Subtraction adds the ones' complement of B, which gives A−B−1. Asserting the carry input turns this into A−B. A flag goes high when all four result bits are 1. With the subtract select and no carry in, this flag reports that the operands are equal.

Top module: `alu4_cla`

## Requirements
- R1: With mode_i=0, sel_i=4'b1001 and cn_ni=1, f_o equals (A+B) mod 16, and cn4_no is 0 exactly when A+B exceeds 15.
- R2: In arithmetic mode, cn_ni=0 adds one to the result of the selected function, so with sel_i=4'b1001 f_o equals (A+B+1) mod 16.
- R3: With mode_i=0 and sel_i=4'b0110, f_o equals (A−B−1) mod 16 when cn_ni=1 and (A−B) mod 16 when cn_ni=0. cn4_no is 0 when no borrow occurs.
- R4: In arithmetic mode with cn_ni=1, select 4'b0000 passes A, select 4'b1100 gives 2A mod 16, and select 4'b1111 gives (A−1) mod 16.
- R5: With mode_i=1, the selects give these functions: 0110 A^B, 1001 ~(A^B), 1011 A&B, 1110 A|B, 0001 ~(A|B), 0100 ~(A&B), 1111 A, 0000 ~A, 0011 all zeros, 1100 all ones. The remaining codes give 0010 ~A&B, 0101 ~B, 0111 A&~B, 1000 ~A|B, 1010 B and 1101 A|~B.
- R6: With mode_i=1, cn_ni has no effect on f_o.
- R7: grp_gen_no is 0 when the group produces a carry out of its own accord. grp_prop_no is 0 when every bit position propagates, that is, when an incoming carry would pass through the whole group.
- R8: cn4_no is low exactly when the group generates a carry, or when the group propagates and cn_ni is low.
- R9: all_ones_o is 1 exactly when f_o is 4'b1111. With mode_i=0, sel_i=4'b0110 and cn_ni=1, all_ones_o is therefore 1 exactly when A equals B.
- R10: For every combination of A, B, select, mode and carry input, every output matches a behavioural reference model.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| sel_i | input | 4 | Function select |
| mode_i | input | 1 | 1 selects logic functions, 0 selects arithmetic |
| cn_ni | input | 1 | Carry input, active low |
| f_o | output | 4 | Result |
| cn4_no | output | 1 | Carry output, active low |
| grp_gen_no | output | 1 | Group generate, active low |
| grp_prop_no | output | 1 | Group propagate, active low |
| all_ones_o | output | 1 | High when every result bit is 1 |

## Verification
Immediate assertions are evaluated whenever the inputs settle. They check that the carry output agrees with the group generate and propagate terms, that a generating group always carries out, that the add select gives the integer sum, that the logic XOR select ignores the carry, and that the equality flag follows operand equality under the subtract select. The full function tables of both modes can only be shown by the bench's scenarios. These scenarios include the carry-in effect on every arithmetic code, the borrow behaviour of subtraction, and the exhaustive sweep against an integer reference model.

// File: rtl/alu4_pkg.sv
package alu4_pkg;
  localparam int unsigned ALU_W = 4;
  localparam int unsigned SEL_W = 4;

  localparam logic [SEL_W-1:0] SEL_ADD = 4'b1001;
  localparam logic [SEL_W-1:0] SEL_SUB = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_XOR = 4'b0110;
endpackage

// File: rtl/alu4_terms.sv
module alu4_terms #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [3:0]   sel_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prop_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // propagate: s0 picks B, s1 picks ~B; generate: s3 keeps B, s2 keeps ~B
    assign prop_o[i] = a_i[i] | (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
    assign gen_o[i]  = (a_i[i] & b_i[i] & sel_i[3]) | (a_i[i] & ~b_i[i] & sel_i[2]);
  end
endmodule

// File: rtl/alu4_lookahead.sv
module alu4_lookahead #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] prop_i,
  input  logic         c_i,
  output logic [W-1:0] carry_o,
  output logic         c_out_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);
  logic [W:0] carry;

  // flat sum-of-products per position, no bit-to-bit ripple
  always_comb begin
    carry[0] = c_i;
    for (int i = 0; i < W; i++) begin
      logic acc;
      logic term;
      acc = c_i;
      for (int j = 0; j <= i; j++) acc = acc & prop_i[j];
      for (int j = 0; j <= i; j++) begin
        term = gen_i[j];
        for (int k = j + 1; k <= i; k++) term = term & prop_i[k];
        acc = acc | term;
      end
      carry[i+1] = acc;
    end
  end

  always_comb begin
    logic gg;
    logic term;
    gg = 1'b0;
    for (int j = 0; j < W; j++) begin
      term = gen_i[j];
      for (int k = j + 1; k < W; k++) term = term & prop_i[k];
      gg = gg | term;
    end
    grp_gen_o = gg;
  end

  assign grp_prop_o = &prop_i;
  assign carry_o    = carry[W-1:0];
  assign c_out_o    = carry[W];

  always_comb begin
    assert_cout_cascade_R8: assert (c_out_o == (grp_gen_o | (grp_prop_o & c_i)))
      else $error("carry out disagrees with group terms");
  end
endmodule

// File: rtl/alu4_cla.sv
module alu4_cla
  import alu4_pkg::*;
(
  input  logic [ALU_W-1:0] a_i,
  input  logic [ALU_W-1:0] b_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             mode_i,
  input  logic             cn_ni,
  output logic [ALU_W-1:0] f_o,
  output logic             cn4_no,
  output logic             grp_gen_no,
  output logic             grp_prop_no,
  output logic             all_ones_o
);
  logic [ALU_W-1:0] gen;
  logic [ALU_W-1:0] prop;
  logic [ALU_W-1:0] carry;
  logic             c_out;
  logic             grp_gen;
  logic             grp_prop;

  alu4_terms #(.W(ALU_W)) u_terms (
    .a_i    (a_i),
    .b_i    (b_i),
    .sel_i  (sel_i),
    .gen_o  (gen),
    .prop_o (prop)
  );

  alu4_lookahead #(.W(ALU_W)) u_la (
    .gen_i      (gen),
    .prop_i     (prop),
    .c_i        (~cn_ni),
    .carry_o    (carry),
    .c_out_o    (c_out),
    .grp_gen_o  (grp_gen),
    .grp_prop_o (grp_prop)
  );

  // logic mode forces the carry term high, which inverts the half sum
  assign f_o         = gen ^ prop ^ (carry | {ALU_W{mode_i}});
  assign cn4_no      = ~c_out;
  assign grp_gen_no  = ~grp_gen;
  assign grp_prop_no = ~grp_prop;
  assign all_ones_o  = &f_o;

  always_comb begin
    if (!mode_i && sel_i == SEL_ADD)
      assert_add_sum_R1: assert ({~cn4_no, f_o} == ({1'b0, a_i} + {1'b0, b_i} + {4'b0, ~cn_ni}))
        else $error("add select mismatch");
    if (mode_i && sel_i == SEL_XOR)
      assert_logic_xor_R6: assert (f_o == (a_i ^ b_i))
        else $error("logic xor depends on carry");
    if (!mode_i && sel_i == SEL_SUB && cn_ni)
      assert_equal_flag_R9: assert (all_ones_o == (a_i == b_i))
        else $error("equality flag wrong");
    if (!grp_gen_no)
      assert_gen_carries_R7: assert (!cn4_no)
        else $error("generating group did not carry");
  end
endmodule

// File: tb/sim_alu4_cla.sv
`timescale 1ns/1ps
module sim_alu4_cla;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] a, b, sel, f;
  logic       mode, cn_n, cn4_n, gg_n, gp_n, ones;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  alu4_cla u0 (
    .a_i(a), .b_i(b), .sel_i(sel), .mode_i(mode), .cn_ni(cn_n),
    .f_o(f), .cn4_no(cn4_n), .grp_gen_no(gg_n), .grp_prop_no(gp_n),
    .all_ones_o(ones)
  );

  typedef struct packed {
    logic [3:0] f;
    logic       cn4_n;
    logic       gg_n;
    logic       gp_n;
    logic       ones;
  } ref_t;

  function automatic logic [3:0] logic_fn(int s, int x, int y);
    int r;
    case (s)
      0: r = ~x;         1: r = ~(x | y);   2: r = ~x & y;    3: r = 0;
      4: r = ~(x & y);   5: r = ~y;         6: r = x ^ y;     7: r = x & ~y;
      8: r = ~x | y;     9: r = ~(x ^ y);   10: r = y;        11: r = x & y;
      12: r = 15;        13: r = x | ~y;    14: r = x | y;    default: r = x;
    endcase
    return r[3:0];
  endfunction

  function automatic ref_t model(int x, int y, int s, int m, int cn);
    ref_t r;
    int ny, p_word, g_word, sum, cin;
    ny = (~y) & 15;
    // addend pair: first picks A plus selected B terms, second the masked A&B/A&~B
    p_word = x | ((s & 1) ? y : 0) | ((s & 2) ? ny : 0);
    g_word = ((s & 8) ? (x & y) : 0) | ((s & 4) ? (x & ny) : 0);
    cin = (cn == 0) ? 1 : 0;
    sum = p_word + g_word + cin;
    r.gp_n  = (p_word == 15) ? 1'b0 : 1'b1;
    r.gg_n  = ((p_word + g_word) > 15) ? 1'b0 : 1'b1;
    r.cn4_n = (sum > 15) ? 1'b0 : 1'b1;
    if (m != 0) r.f = logic_fn(s, x, y);
    else        r.f = sum[3:0];
    r.ones = (r.f == 4'hF);
    return r;
  endfunction

  task automatic drive(int x, int y, int s, int m, int cn);
    @(posedge clk);
    #1;
    a = x[3:0]; b = y[3:0]; sel = s[3:0]; mode = m[0]; cn_n = cn[0];
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s a=%0d b=%0d s=%0d m=%0d cn_n=%0d act=%0d exp=%0d",
               tag, a, b, sel, mode, cn_n, act, exp);
    end
  endtask

  initial begin
    a = 0; b = 0; sel = 0; mode = 0; cn_n = 1;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // R1 add without carry
    drive(7, 5, 9, 0, 1);  chk("R1 f", f, 12); chk("R1 cn4", cn4_n, 1);
    drive(9, 8, 9, 0, 1);  chk("R1 f", f, 1);  chk("R1 cn4", cn4_n, 0);
    // R2 forced carry
    drive(7, 5, 9, 0, 0);  chk("R2 f", f, 13);
    drive(15, 0, 9, 0, 0); chk("R2 f", f, 0);  chk("R2 cn4", cn4_n, 0);
    // R3 subtraction
    drive(9, 3, 6, 0, 1);  chk("R3 f", f, 5);  chk("R3 cn4", cn4_n, 0);
    drive(9, 3, 6, 0, 0);  chk("R3 f", f, 6);
    drive(3, 9, 6, 0, 0);  chk("R3 f", f, 10); chk("R3 cn4", cn4_n, 1);
    // R4 transfer, double, decrement
    drive(11, 4, 0, 0, 1);  chk("R4 pass", f, 11);
    drive(6, 9, 12, 0, 1);  chk("R4 dbl", f, 12);
    drive(6, 9, 15, 0, 1);  chk("R4 dec", f, 5);
    drive(0, 9, 15, 0, 1);  chk("R4 dec", f, 15);
    // R5 logic table on A=1100 B=1010
    for (int s = 0; s < 16; s++) begin
      drive(12, 10, s, 1, 1);
      chk("R5", f, logic_fn(s, 12, 10));
    end
    // R6 carry ignored in logic mode
    for (int s = 0; s < 16; s++) begin
      drive(5, 3, s, 1, 0);
      chk("R6", f, logic_fn(s, 5, 3));
    end
    // R7 group terms under add
    drive(15, 1, 9, 0, 1); chk("R7 g", gg_n, 0); chk("R7 p", gp_n, 0);
    drive(5, 10, 9, 0, 1); chk("R7 g", gg_n, 1); chk("R7 p", gp_n, 0);
    drive(0, 0, 9, 0, 1);  chk("R7 g", gg_n, 1); chk("R7 p", gp_n, 1);
    // R8 carry through propagating group
    drive(5, 10, 9, 0, 0); chk("R8", cn4_n, 0);
    drive(5, 10, 9, 0, 1); chk("R8", cn4_n, 1);
    // R9 equality flag
    drive(6, 6, 6, 0, 1);  chk("R9", ones, 1);
    drive(6, 7, 6, 0, 1);  chk("R9", ones, 0);

    // R10 exhaustive sweep
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        for (int s = 0; s < 16; s++)
          for (int m = 0; m < 2; m++)
            for (int cn = 0; cn < 2; cn++) begin
              ref_t e;
              e = model(x, y, s, m, cn);
              drive(x, y, s, m, cn);
              chk("R10 f", f, e.f);
              chk("R10 cn4", cn4_n, e.cn4_n);
              chk("R10 g", gg_n, e.gg_n);
              chk("R10 p", gp_n, e.gp_n);
              chk("R10 ones", ones, e.ones);
            end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule